// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

The allocator sits between an in-order decoder and the issue queues. Decoded internal operations arrive one per cycle over a ready/valid handshake. Each carries a class code, a span that says how many adjacent slots a cracked operation needs, and a tag. The allocator packs these operations into dispatch groups of five slots. Slots 1 to 4 hold ordinary operations in program order. Slot 5 is kept for a branch, and a branch always closes the group.

A group closes in three cases: a branch arrives, the next operation does not fit in the remaining legal slots, or the decoder has nothing to send while a flush request is raised. A closed group is shown to the dispatch stage with one bit per slot for valid, a tag, a class and a load/store pipe choice. It stays there until the dispatch stage accepts it. In the cycle a held group is accepted, the next operation can already enter a fresh group.

The controller has two states. FILL collects operations. HOLD presents a closed group. There are three transitions. CLOSE goes from FILL to HOLD, or from HOLD to HOLD when a branch arrives in the accept cycle. RELEASE goes from HOLD to FILL on accept when nothing closes. STAY keeps FILL while the group is still open.

Top module: `dgroup_packer`

## Requirements
- R1: After reset `grp_valid` is low, `slot_vld` is all zero, and `in_ready` is high for an ordinary operation.
- R2: Class codes are 0 ordinary, 1 load/store, 2 serializing, 3 divide, 4 first-slot-only and 5 branch; codes 6 and 7 act as ordinary. An ordinary operation takes `in_span`+1 adjacent slots starting at the lowest free slot among slots 1 to 4. All of its slots carry its tag. Filled slots always form a run that starts at slot 1.
- R3: A branch is placed in slot 5, which is `slot_vld` bit 4, and closes the group at once. Unfilled earlier slots stay invalid.
- R4: A single-slot load/store (`in_span` = 0) uses pipe 1 (`slot_pipe` bit 0) in slot 1 or slot 4, and pipe 2 (`slot_pipe` bit 1) in slot 2 or slot 3.
- R5: A load/store with `in_span` not zero takes two slots and may start in slot 1, 2 or 3. Both of its slots use pipe 1 when it starts in slot 1 and pipe 2 otherwise.
- R6: A serializing operation fills slots 1 to 4 and is accepted only into an empty group.
- R7: A divide fills slots 1 and 2 and is accepted only into an empty group.
- R8: A first-slot-only operation is placed only in slot 1.
- R9: An operation that does not fit closes the current group without being taken. It then becomes the first entry of the next group.
- R10: With `in_valid` low, `flush_req` high and at least one slot filled, the group closes. With an empty group, `flush_req` has no effect.
- R11: While a group is held and `dsp_accept` is low, `in_ready` is low and the slot outputs do not change. In the cycle `dsp_accept` is high, `in_ready` rises again, so an operation can enter the new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoder offers an operation |
| in_ready | output | 1 | Operation is taken this cycle |
| in_cls | input | 3 | Operation class code |
| in_span | input | 2 | Slots needed minus one |
| in_tag | input | TAGW | Operation tag |
| flush_req | input | 1 | Close a partial group while the input is idle |
| dsp_accept | input | 1 | Dispatch stage takes the held group |
| grp_valid | output | 1 | A closed group is presented |
| slot_vld | output | NSLOT | Per-slot valid, bit 0 = slot 1 |
| slot_tag | output | NSLOT*TAGW | Per-slot tag |
| slot_cls | output | NSLOT*3 | Per-slot class code |
| slot_pipe | output | NSLOT | Load/store pipe, 0 = pipe 1, 1 = pipe 2 |

## Verification
An operation is taken on the edge where `in_ready` and `in_valid` are both high. A branch, a non-fitting operation or a flush request shows up as `grp_valid` one edge later. A held group leaves on the first edge where `dsp_accept` is high, and `in_ready` responds in that same cycle because it is combinational. The driver changes inputs on the falling edge and samples `in_ready` late in the low phase. The scoreboard monitor compares each group against the queue shortly after the falling edge, and only in cycles where the group is both valid and accepted.

// File: rtl/dgp_pkg.sv
package dgp_pkg;

    typedef enum logic [2:0] {
        CL_ALU   = 3'd0,
        CL_LDST  = 3'd1,
        CL_SER   = 3'd2,
        CL_DIV   = 3'd3,
        CL_FIRST = 3'd4,
        CL_BR    = 3'd5,
        CL_RSV6  = 3'd6,
        CL_RSV7  = 3'd7
    } op_cls_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } grp_state_e;

    localparam int CLS_W = 3;

endpackage

// File: rtl/dgp_fit.sv
module dgp_fit
    import dgp_pkg::*;
#(
    parameter int NREG = 4,
    parameter int PW   = 3
) (
    input  op_cls_e         cls,
    input  logic [1:0]      span,
    input  logic [PW-1:0]   pos,
    output logic            fits,
    output logic [PW-1:0]   need,
    output logic            is_br
);

    logic [PW-1:0] span_ext;
    logic [PW-1:0] ldst_need;

    assign span_ext  = {{(PW-2){1'b0}}, span} + PW'(1);
    assign ldst_need = (span != 2'd0) ? PW'(2) : PW'(1);

    always_comb begin
        need  = '0;
        fits  = 1'b0;
        is_br = 1'b0;
        unique case (cls)
            CL_BR: begin
                is_br = 1'b1;
                fits  = 1'b1;
            end
            CL_SER: begin
                need = PW'(NREG);
                fits = (pos == '0);
            end
            CL_DIV: begin
                need = PW'(2);
                fits = (pos == '0);
            end
            CL_FIRST: begin
                need = PW'(1);
                fits = (pos == '0);
            end
            CL_LDST: begin
                need = ldst_need;
                fits = (int'(pos) + int'(ldst_need)) <= NREG;
            end
            default: begin
                need = span_ext;
                fits = (int'(pos) + int'(span_ext)) <= NREG;
            end
        endcase
    end

endmodule

// File: rtl/dgp_place.sv
module dgp_place
    import dgp_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int TAGW  = 8,
    parameter int PW    = 3
) (
    input  logic                    take,
    input  logic                    is_br,
    input  op_cls_e                 cls,
    input  logic [TAGW-1:0]         tag,
    input  logic [PW-1:0]           pos,
    input  logic [PW-1:0]           need,
    input  logic [NSLOT-1:0]        base_v,
    input  logic [NSLOT*TAGW-1:0]   base_tag,
    input  logic [NSLOT*CLS_W-1:0]  base_cls,
    input  logic [NSLOT-1:0]        base_pipe,
    output logic [NSLOT-1:0]        nxt_v,
    output logic [NSLOT*TAGW-1:0]   nxt_tag,
    output logic [NSLOT*CLS_W-1:0]  nxt_cls,
    output logic [NSLOT-1:0]        nxt_pipe
);

    localparam int NREG = NSLOT - 1;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg_slot
        logic hit;
        logic pipe2;
        logic mid_slot;

        assign mid_slot = (gi != 0) && (gi != NREG - 1);
        assign hit      = take && !is_br
                          && (gi >= int'(pos))
                          && (gi < int'(pos) + int'(need));
        assign pipe2    = (need == PW'(1)) ? mid_slot : (pos != '0);

        assign nxt_v[gi] = base_v[gi] | hit;
        assign nxt_tag[gi*TAGW +: TAGW] = hit ? tag : base_tag[gi*TAGW +: TAGW];
        assign nxt_cls[gi*CLS_W +: CLS_W] = hit ? cls : base_cls[gi*CLS_W +: CLS_W];
        assign nxt_pipe[gi] = hit ? ((cls == CL_LDST) && pipe2) : base_pipe[gi];
    end

    logic br_hit;
    assign br_hit = take && is_br;

    assign nxt_v[NREG] = base_v[NREG] | br_hit;
    assign nxt_tag[NREG*TAGW +: TAGW] = br_hit ? tag : base_tag[NREG*TAGW +: TAGW];
    assign nxt_cls[NREG*CLS_W +: CLS_W] = br_hit ? cls : base_cls[NREG*CLS_W +: CLS_W];
    assign nxt_pipe[NREG] = base_pipe[NREG];

endmodule

// File: rtl/dgroup_packer.sv
module dgroup_packer
    import dgp_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int TAGW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [2:0]              in_cls,
    input  logic [1:0]              in_span,
    input  logic [TAGW-1:0]         in_tag,
    input  logic                    flush_req,
    input  logic                    dsp_accept,
    output logic                    grp_valid,
    output logic [NSLOT-1:0]        slot_vld,
    output logic [NSLOT*TAGW-1:0]   slot_tag,
    output logic [NSLOT*CLS_W-1:0]  slot_cls,
    output logic [NSLOT-1:0]        slot_pipe
);

    localparam int NREG = NSLOT - 1;
    localparam int PW   = $clog2(NSLOT);

    grp_state_e                 state_q, state_d;
    logic [PW-1:0]              pos_q, pos_d, eff_pos;
    logic [NSLOT-1:0]           v_q, pipe_q, base_v, base_pipe, n_v, n_pipe;
    logic [NSLOT*TAGW-1:0]      tag_q, base_tag, n_tag;
    logic [NSLOT*CLS_W-1:0]     cls_q, base_cls, n_cls;
    logic                       clear, can_take, take, close, load;
    logic                       fits, is_br;
    logic [PW-1:0]              need;
    op_cls_e                    op_cls;

    assign op_cls = op_cls_e'(in_cls);

    dgp_fit #(.NREG(NREG), .PW(PW)) i_fit (
        .cls   (op_cls),
        .span  (in_span),
        .pos   (eff_pos),
        .fits  (fits),
        .need  (need),
        .is_br (is_br)
    );

    dgp_place #(.NSLOT(NSLOT), .TAGW(TAGW), .PW(PW)) i_place (
        .take      (take),
        .is_br     (is_br),
        .cls       (op_cls),
        .tag       (in_tag),
        .pos       (eff_pos),
        .need      (need),
        .base_v    (base_v),
        .base_tag  (base_tag),
        .base_cls  (base_cls),
        .base_pipe (base_pipe),
        .nxt_v     (n_v),
        .nxt_tag   (n_tag),
        .nxt_cls   (n_cls),
        .nxt_pipe  (n_pipe)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition and handshake decisions
    always_comb begin
        clear    = 1'b0;
        can_take = 1'b0;
        unique case (state_q)
            ST_FILL: can_take = 1'b1;
            ST_HOLD: begin
                clear    = dsp_accept;
                can_take = dsp_accept;
            end
            default: can_take = 1'b0;
        endcase

        eff_pos   = clear ? '0 : pos_q;
        base_v    = clear ? '0 : v_q;
        base_tag  = clear ? '0 : tag_q;
        base_cls  = clear ? '0 : cls_q;
        base_pipe = clear ? '0 : pipe_q;

        in_ready = can_take && fits;
        take     = in_ready && in_valid;

        // CLOSE: branch placed, non-fitting op, or idle flush of a partial group
        close = (take && is_br)
              || (can_take && in_valid && !fits)
              || (can_take && !in_valid && flush_req && (eff_pos != '0));

        state_d = state_q;
        if (close) begin
            state_d = ST_HOLD;
        end else if (clear) begin
            state_d = ST_FILL;
        end

        pos_d = take ? (eff_pos + need) : eff_pos;
        load  = can_take;
    end

    // Group contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            v_q    <= '0;
            tag_q  <= '0;
            cls_q  <= '0;
            pipe_q <= '0;
        end else if (load) begin
            pos_q  <= pos_d;
            v_q    <= n_v;
            tag_q  <= n_tag;
            cls_q  <= n_cls;
            pipe_q <= n_pipe;
        end
    end

    assign grp_valid = (state_q == ST_HOLD);
    assign slot_vld  = v_q;
    assign slot_tag  = tag_q;
    assign slot_cls  = cls_q;
    assign slot_pipe = pipe_q;

    // Assertions
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !dsp_accept) |=> (grp_valid && $stable(slot_vld) && $stable(slot_tag))); // R11
    AST_NO_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !dsp_accept) |-> !in_ready); // R11
    AST_BR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && slot_vld[NREG]) |-> (slot_cls[NREG*CLS_W +: CLS_W] == CL_BR)); // R3
    AST_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> ((slot_vld[NREG-1:0] & (slot_vld[NREG-1:0] + 1'b1)) == '0)); // R2
    AST_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (slot_vld != '0)); // R10

    for (genvar ai = 1; ai < NREG; ai++) begin : g_chk_first
        AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[ai] |-> (slot_cls[ai*CLS_W +: CLS_W] != CL_FIRST)); // R8
    end

endmodule

// File: tb/test_dgroup_packer.sv
module test_dgroup_packer;

    localparam int NSLOT = 5;
    localparam int TAGW  = 8;
    localparam logic [2:0] C_ALU = 3'd0, C_LS = 3'd1, C_SER = 3'd2,
                           C_DIV = 3'd3, C_FST = 3'd4, C_BR = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_cls = '0;
    logic [1:0] in_span = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic flush_req = 1'b0;
    logic dsp_accept = 1'b1;
    logic grp_valid;
    logic [NSLOT-1:0] slot_vld, slot_pipe;
    logic [NSLOT*TAGW-1:0] slot_tag;
    logic [NSLOT*3-1:0] slot_cls;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [4:0]  v;
        logic [39:0] t;
        logic [4:0]  p;
        string       req;
    } grp_t;
    grp_t exq[$];

    always #10 clk = ~clk;

    dgroup_packer #(.NSLOT(NSLOT), .TAGW(TAGW)) i_dgroup_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_span(in_span), .in_tag(in_tag),
        .flush_req(flush_req), .dsp_accept(dsp_accept),
        .grp_valid(grp_valid), .slot_vld(slot_vld), .slot_tag(slot_tag),
        .slot_cls(slot_cls), .slot_pipe(slot_pipe)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_grp(input logic [4:0] v,
                              input logic [7:0] t0, t1, t2, t3, t4,
                              input logic [4:0] p, input string req);
        grp_t g;
        g.v = v;
        g.t = {t4, t3, t2, t1, t0};
        g.p = p;
        g.req = req;
        exq.push_back(g);
    endtask

    // Driver: offers one operation, returns on the falling edge after it is taken
    task automatic send(input logic [2:0] c, input logic [1:0] s, input logic [7:0] t);
        bit r;
        in_valid = 1'b1;
        in_cls = c;
        in_span = s;
        in_tag = t;
        do begin
            #5 r = in_ready;
            @(negedge clk);
        end while (!r);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exq.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compares each accepted group with the queue head
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && grp_valid && dsp_accept) begin
                if (exq.size() == 0) begin
                    chk("R2", "unexpected group vld", 64'(slot_vld), 64'h0);
                end else begin
                    grp_t g;
                    g = exq.pop_front();
                    chk(g.req, "slot_vld", 64'(slot_vld), 64'(g.v));
                    chk(g.req, "slot_tag", 64'(slot_tag), 64'(g.t));
                    chk(g.req, "slot_pipe", 64'(slot_pipe), 64'(g.p));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk("R1", "grp_valid", 64'(grp_valid), 64'h0);
        chk("R1", "slot_vld", 64'(slot_vld), 64'h0);
        chk("R1", "in_ready", 64'(in_ready), 64'h1);
        @(negedge clk);

        // R2/R3: four ordinary ops then branch
        expect_grp(5'b11111, 1, 2, 3, 4, 5, 5'b00000, "R2");
        send(C_ALU, 0, 1); send(C_ALU, 0, 2); send(C_ALU, 0, 3); send(C_ALU, 0, 4);
        send(C_BR, 0, 5);

        // R4: single load/stores in every slot
        expect_grp(5'b11111, 10, 11, 12, 13, 14, 5'b00110, "R4");
        send(C_LS, 0, 10); send(C_LS, 0, 11); send(C_LS, 0, 12); send(C_LS, 0, 13);
        send(C_BR, 0, 14);

        // R9: non-fitting op closes group; R3 branch with gaps
        expect_grp(5'b01111, 20, 21, 21, 22, 0, 5'b00110, "R9");
        expect_grp(5'b10001, 23, 0, 0, 0, 24, 5'b00000, "R3");
        send(C_ALU, 0, 20); send(C_LS, 1, 21); send(C_ALU, 0, 22); send(C_ALU, 0, 23);
        send(C_BR, 0, 24);

        // R5: paired load/stores from slot 1 and slot 3
        expect_grp(5'b11111, 25, 25, 26, 26, 27, 5'b01100, "R5");
        send(C_LS, 1, 25); send(C_LS, 1, 26); send(C_BR, 0, 27);

        // R6/R7/R8: empty-group classes
        expect_grp(5'b00001, 31, 0, 0, 0, 0, 5'b00000, "R6");
        expect_grp(5'b01111, 30, 30, 30, 30, 0, 5'b00000, "R6");
        expect_grp(5'b00001, 32, 0, 0, 0, 0, 5'b00000, "R7");
        expect_grp(5'b00011, 33, 33, 0, 0, 0, 5'b00000, "R7");
        expect_grp(5'b11111, 34, 35, 35, 35, 36, 5'b00000, "R8");
        send(C_ALU, 0, 31); send(C_SER, 0, 30); send(C_ALU, 0, 32);
        send(C_DIV, 0, 33); send(C_FST, 0, 34); send(C_ALU, 2, 35);
        send(C_BR, 0, 36);
        drain();

        // R10: flush of a partial group, then flush ignored when empty
        expect_grp(5'b00001, 40, 0, 0, 0, 0, 5'b00000, "R10");
        send(C_ALU, 0, 40);
        flush_req = 1'b1;
        drain();
        for (int k = 0; k < 3; k++) begin
            #5 chk("R10", "grp_valid empty flush", 64'(grp_valid), 64'h0);
            @(negedge clk);
        end
        flush_req = 1'b0;

        // R11: backpressure from dispatch
        dsp_accept = 1'b0;
        expect_grp(5'b10001, 50, 0, 0, 0, 51, 5'b00000, "R11");
        expect_grp(5'b00001, 52, 0, 0, 0, 0, 5'b00000, "R11");
        send(C_ALU, 0, 50); send(C_BR, 0, 51);
        in_valid = 1'b1; in_cls = C_ALU; in_span = 0; in_tag = 52;
        for (int k = 0; k < 3; k++) begin
            #5;
            chk("R11", "in_ready held", 64'(in_ready), 64'h0);
            chk("R11", "grp_valid held", 64'(grp_valid), 64'h1);
            chk("R11", "slot1 tag held", 64'(slot_tag[7:0]), 64'd50);
            @(negedge clk);
        end
        dsp_accept = 1'b1;
        #5 chk("R11", "in_ready on accept", 64'(in_ready), 64'h1);
        @(negedge clk);
        in_valid = 1'b0;
        flush_req = 1'b1;
        drain();
        flush_req = 1'b0;
        repeat (2) @(negedge clk);
        summary();
    end

endmodule